// File: doc/BRIEF.md
# Streamed Pixel Comparator Rule Row

This block is one rule of a run-time reconfigurable pattern classifier. It holds a row of comparator units, six by default. Each unit is told through a small configuration register which pixel of a 64-pixel, 8-bit image it should look at. It is also told whether to test that pixel as strictly above or strictly below an 8-bit threshold. The row fires only when every unit's test holds. An outer agent changes what the rule recognises only by rewriting these registers.

The image arrives as a stream of one pixel per accepted cycle, after a start pulse. There is no wide selector per unit. Each unit keeps a copy of the pixel whose position in the stream equals its configured address. Once the last pixel has been accepted, the row reports its verdict together with a one-cycle done pulse. The verdict stays on the output until the next frame begins.

Configuration writes go into a staging copy. The start pulse moves the staging copy into the working copy, so a frame in flight always sees one consistent rule.

Top module: `rule_row`

## Requirements
- R1: While reset is low and after its release, `row_done` and `row_match` are 0, and every staging and working unit setting is 0.
- R2: A write with `cfg_we` high stores `cfg_data` for unit `cfg_unit` (unit 0 is the first field of a row setting). Bits [14:9] are the pixel address, bit [8] is the test select and bits [7:0] are the threshold. A write to an index of `N_UNITS` or above changes nothing.
- R3: Test select 0 passes only when the chosen pixel is strictly greater than the threshold. Equality fails.
- R4: Test select 1 passes only when the chosen pixel is strictly less than the threshold. Equality fails.
- R5: `row_match` is 1 after a frame only if every unit passed. It rises only together with `row_done`.
- R6: The stream index starts at 0 on `frame_start` and advances by one only on cycles with `pix_valid` high. Idle cycles inside a frame are allowed. A unit uses the pixel whose index equals its address, including index 63, and several units may share one address.
- R7: `row_done` is high for exactly the one cycle after the cycle that accepts pixel 63. `row_match` is valid in that cycle and is held until the next `frame_start`, which clears it.
- R8: Writes take effect at the next `frame_start`, so a write made while a frame is streaming does not change that frame's verdict.
- R9: `pix_valid` cycles outside a started frame are ignored. A `frame_start` in the middle of a frame abandons it and restarts the index at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_unit | input | 3 | Index of the unit to write |
| cfg_data | input | 15 | Address, test select and threshold for that unit |
| frame_start | input | 1 | Begins a frame and loads the staged settings |
| pix_valid | input | 1 | The pixel on `pix_data` belongs to the stream |
| pix_data | input | 8 | Pixel value |
| row_match | output | 1 | Row verdict, held until the next frame start |
| row_done | output | 1 | One-cycle pulse: verdict now valid |

## Verification
The verdict for a frame is due in the cycle right after the edge that accepts pixel 63. It does not come later when idle cycles were inserted earlier in the frame, since only accepted pixels advance the index. The bench drives every input on the falling edge. It updates a behavioural model on the rising edge and compares `row_done` and `row_match` against that model at the next falling edge, so every result is checked in the cycle it becomes due. Directed checks also read the verdict at the falling edge after the last pixel. They read it again a few cycles later, to confirm it is held and that the done pulse has ended.

// File: rtl/rule_row.sv
module rule_row #(
  parameter int N_UNITS = 6,
  parameter int PIX_W   = 8,
  parameter int NUM_PIX = 64,
  localparam int ADDR_W = $clog2(NUM_PIX),
  localparam int CFG_W  = ADDR_W + 1 + PIX_W,
  localparam int UW     = (N_UNITS > 1) ? $clog2(N_UNITS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [UW-1:0]     cfg_unit,
  input  logic [CFG_W-1:0]  cfg_data,
  input  logic              frame_start,
  input  logic              pix_valid,
  input  logic [PIX_W-1:0]  pix_data,
  output logic              row_match,
  output logic              row_done
);

  logic [ADDR_W-1:0]  idx;
  logic               armed;
  logic [N_UNITS-1:0] unit_ok;

  wire take  = armed & pix_valid & ~frame_start;
  wire last  = take & (idx == ADDR_W'(NUM_PIX - 1));
  wire wr_ok = cfg_we & ({1'b0, cfg_unit} < (UW+1)'(N_UNITS));

  for (genvar g = 0; g < N_UNITS; g++) begin : g_unit
    logic [CFG_W-1:0] staged, working;
    logic [PIX_W-1:0] held;

    wire [ADDR_W-1:0] sel   = working[CFG_W-1 -: ADDR_W];
    wire              below = working[PIX_W];
    wire [PIX_W-1:0]  thr   = working[PIX_W-1:0];
    wire              hit   = take & (idx == sel);
    wire [PIX_W-1:0]  val   = hit ? pix_data : held;

    assign unit_ok[g] = below ? (val < thr) : (val > thr);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        staged  <= '0;
        working <= '0;
        held    <= '0;
      end else begin
        if (wr_ok && cfg_unit == UW'(g)) staged <= cfg_data;
        if (frame_start) working <= staged;
        if (hit) held <= pix_data;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed     <= 1'b0;
      idx       <= '0;
      row_match <= 1'b0;
      row_done  <= 1'b0;
    end else if (frame_start) begin
      armed     <= 1'b1;
      idx       <= '0;
      row_match <= 1'b0;
      row_done  <= 1'b0;
    end else begin
      row_done <= last;
      if (last) begin
        armed     <= 1'b0;
        row_match <= &unit_ok;
      end else if (take) begin
        idx <= idx + 1'b1;
      end
    end
  end

  assert_done_one_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    row_done |=> !row_done);

  assert_done_after_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
    row_done |-> $past(armed && pix_valid && !frame_start && idx == ADDR_W'(NUM_PIX - 1)));

  assert_match_rises_with_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(row_match) |-> row_done);

  assert_match_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!row_done && !$past(frame_start)) |-> $stable(row_match));

  assert_start_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (!row_match && !row_done));

endmodule

// File: tb/tb_rule_row.sv
module tb_rule_row;
  localparam int N = 6;

  logic clk = 0, rst_n = 0;
  logic cfg_we = 0, frame_start = 0, pix_valid = 0;
  logic [2:0] cfg_unit = 0;
  logic [14:0] cfg_data = 0;
  logic [7:0] pix_data = 0;
  logic row_match, row_done;

  rule_row dut (.clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_unit(cfg_unit),
    .cfg_data(cfg_data), .frame_start(frame_start), .pix_valid(pix_valid),
    .pix_data(pix_data), .row_match(row_match), .row_done(row_done));

  always #5 clk = ~clk;

  int checks = 0, errors = 0, cycles = 0;
  bit cmp_on = 0;

  // behavioural reference
  int sh_a[N], sh_f[N], sh_k[N], ac_a[N], ac_f[N], ac_k[N], cap[N];
  bit m_armed, m_done, m_match;
  int m_idx;

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      for (int u = 0; u < N; u++) begin
        sh_a[u] = 0; sh_f[u] = 0; sh_k[u] = 0;
        ac_a[u] = 0; ac_f[u] = 0; ac_k[u] = 0; cap[u] = 0;
      end
      m_armed = 0; m_done = 0; m_match = 0; m_idx = 0;
    end else begin
      m_done = 0;
      if (frame_start) begin
        for (int u = 0; u < N; u++) begin
          ac_a[u] = sh_a[u]; ac_f[u] = sh_f[u]; ac_k[u] = sh_k[u];
        end
        m_armed = 1; m_idx = 0; m_match = 0;
      end else if (m_armed && pix_valid) begin
        for (int u = 0; u < N; u++) if (ac_a[u] == m_idx) cap[u] = pix_data;
        if (m_idx == 63) begin
          m_match = 1;
          for (int u = 0; u < N; u++)
            if (ac_f[u] == 0 ? !(cap[u] > ac_k[u]) : !(cap[u] < ac_k[u])) m_match = 0;
          m_done = 1; m_armed = 0;
        end else m_idx++;
      end
      if (cfg_we && cfg_unit < N) begin
        sh_a[cfg_unit] = cfg_data[14:9];
        sh_f[cfg_unit] = cfg_data[8];
        sh_k[cfg_unit] = cfg_data[7:0];
      end
    end
  end

  always @(negedge clk) if (cmp_on) begin
    checks++;
    if (row_done !== m_done || row_match !== m_match) begin
      errors++;
      $display("FAIL R7 model compare at cycle %0d: done=%b match=%b expected done=%b match=%b",
               cycles, row_done, row_match, m_done, m_match);
    end
  end

  task automatic chk(input bit act, input bit exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic wcfg(input int u, input int a, input int f, input int k);
    @(negedge clk);
    cfg_we = 1; cfg_unit = 3'(u); cfg_data = {6'(a), 1'(f), 8'(k)};
    @(negedge clk);
    cfg_we = 0;
  endtask

  logic [7:0] img [64];

  task automatic run_frame(input bit gaps, input int wr_at, input bit exp, input string tag);
    @(negedge clk); frame_start = 1;
    @(negedge clk); frame_start = 0;
    for (int i = 0; i < 64; i++) begin
      pix_valid = 1; pix_data = img[i];
      cfg_we = (i == wr_at);
      cfg_unit = 0; cfg_data = {6'd0, 1'b1, 8'd0};
      @(negedge clk);
      cfg_we = 0;
      if (gaps && (i % 7 == 3) && i != 63) begin
        pix_valid = 0; pix_data = 8'hEE; @(negedge clk);
      end
    end
    pix_valid = 0;
    chk(row_done, 1'b1, {tag, " done"});
    chk(row_match, exp, {tag, " match"});
  endtask

  task automatic base_img();
    for (int i = 0; i < 64; i++) img[i] = 8'd100;
  endtask

  task automatic base_cfg();
    wcfg(0, 0, 0, 50);
    wcfg(1, 5, 1, 200);
    wcfg(2, 17, 0, 99);
    wcfg(3, 33, 1, 101);
    wcfg(4, 50, 0, 0);
    wcfg(5, 63, 1, 255);
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    cmp_on = 1;
    chk(row_done, 1'b0, "R1 done in reset");
    chk(row_match, 1'b0, "R1 match in reset");
    rst_n = 1;
    @(negedge clk);
    chk(row_done, 1'b0, "R1 done after reset");

    base_img(); base_cfg();
    run_frame(0, -1, 1'b1, "R2 R5 all units pass");
    repeat (3) @(negedge clk);
    chk(row_match, 1'b1, "R7 match held");
    chk(row_done, 1'b0, "R7 done is a pulse");

    img[17] = 8'd99;
    run_frame(0, -1, 1'b0, "R3 greater-than equality fails");
    img[17] = 8'd100; img[33] = 8'd101;
    run_frame(0, -1, 1'b0, "R4 less-than equality fails");
    img[33] = 8'd100; img[63] = 8'd255;
    run_frame(0, -1, 1'b0, "R6 last pixel captured");
    img[63] = 8'd254;
    run_frame(1, -1, 1'b1, "R6 idle cycles inside frame");

    base_img(); img[0] = 8'd50;
    run_frame(0, -1, 1'b0, "R5 one unit fails");
    base_img();

    wcfg(3, 0, 1, 101);
    run_frame(0, -1, 1'b1, "R6 shared address");
    wcfg(3, 33, 1, 101);

    run_frame(0, 30, 1'b1, "R8 mid-frame write not applied");
    run_frame(0, -1, 1'b0, "R8 write applied next frame");
    wcfg(0, 0, 0, 50);

    wcfg(7, 0, 1, 0);
    run_frame(0, -1, 1'b1, "R2 out-of-range unit ignored");

    for (int i = 0; i < 10; i++) begin
      pix_valid = 1; pix_data = 8'd0; @(negedge clk);
    end
    pix_valid = 0;
    chk(row_done, 1'b0, "R9 stray pixels give no done");
    chk(row_match, 1'b1, "R9 stray pixels keep verdict");

    @(negedge clk); frame_start = 1;
    @(negedge clk); frame_start = 0;
    for (int i = 0; i < 20; i++) begin
      pix_valid = 1; pix_data = 8'd0; @(negedge clk);
    end
    pix_valid = 0;
    chk(row_done, 1'b0, "R9 partial frame no done");
    run_frame(0, -1, 1'b1, "R9 restart mid-frame");

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule